// File: doc/BRIEF.md
# Boost Frequency Update Unit

This block serves one channel of a bus activity monitor. Each time the channel reports that its sampled activity has stayed above or below a watermark for several periods in a row, software or a sequencer pulses `start`. The unit then works out a new boost frequency, chooses which of the two consecutive-breach interrupts stay armed, derives the frequency the channel would like to run at, and computes fresh watermark values for the next sampling period.

The boost grows when activity stays high. The old boost is scaled by a growth percentage and a fixed step is added, and the sum is capped at the maximum frequency. The boost shrinks when activity stays low. The old boost is scaled by a decay percentage, and a result below half a step falls to zero. An optional dependency threshold on the average count can keep the low-activity interrupt armed, or remove it once the boost has reached zero.

All arithmetic runs in sequence through one multiplier and one iterative divider. The divider resolves `DIV_BITS` quotient bits per clock. Every frequency is in kHz, and every count is in events per sampling period of `PERIOD` units.

Top module: `boost_update_unit`

## Requirements
- R1: A `start` pulse while `busy` is low raises `busy` on the next clock. When all outputs are valid, `done` pulses high for exactly one cycle and `busy` falls at the same edge. A `start` seen while `busy` is high is ignored, so the run keeps its original completion time. The outputs hold their values from `done` until the next accepted `start`.
- R2: When `brk_upper` = 1, the new boost is `boost_in*up_pct/100 + STEP`. If that value is at or above `max_khz`, the boost becomes `max_khz` and `arm_above` copies `arm_above_in`. Otherwise `arm_above` = 1. Before the dependency rule of R5 is applied, `arm_below` = 1.
- R3: When only `brk_lower` = 1, the new boost is `boost_in*down_pct/100`. A value below STEP/2 becomes 0 and `arm_below` copies `arm_below_in`. Otherwise `arm_below` = 1. In both cases `arm_above` = 1.
- R4: `brk_upper` takes priority over `brk_lower` when both are 1. When neither is set, the boost equals `boost_in` and both arm outputs copy their inputs.
- R5: When `dep_thr` is nonzero and `avg_in >= dep_thr`, `arm_below` = 1. When `dep_thr` is nonzero and `avg_in < dep_thr` and the new boost is 0, `arm_below` = 0. When `dep_thr` = 0, the rule has no effect.
- R6: `target_out = ((avg_in/PERIOD) * (10000/up_thr)) / 100 + new boost`. Every division truncates, and the sum is taken modulo 2^W.
- R7: `wm_upper = cur_khz*PERIOD*up_thr/100` and `wm_lower = cur_khz*PERIOD*down_thr/100`. The intermediate products are wide enough not to overflow.
- R8: `band = (max_khz*BAND_PERMIL/1000 mod 2^W) * PERIOD mod 2^W`. The unit outputs `avg_wm_upper = avg_in + band` and `avg_wm_lower = max(avg_in, band) - band`, so the lower value is 0 whenever `avg_in <= band`.
- R9: After reset, `busy`, `done`, every value output and both arm outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an update; inputs stay stable until done |
| brk_upper | input | 1 | Consecutive above-watermark breach flag |
| brk_lower | input | 1 | Consecutive below-watermark breach flag |
| arm_above_in | input | 1 | Present above-breach interrupt enable |
| arm_below_in | input | 1 | Present below-breach interrupt enable |
| boost_in | input | W | Present boost frequency (kHz) |
| avg_in | input | W | Sampled average activity count |
| cur_khz | input | W | Current bus frequency (kHz) |
| max_khz | input | W | Maximum bus frequency (kHz) |
| up_pct | input | CW | Boost growth percentage |
| down_pct | input | CW | Boost decay percentage |
| up_thr | input | CW | Upper watermark percentage, nonzero |
| down_thr | input | CW | Lower watermark percentage |
| dep_thr | input | W | Dependency threshold on the average, 0 disables it |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse, outputs valid |
| boost_out | output | W | New boost frequency (kHz) |
| target_out | output | W | Target frequency (kHz) |
| wm_upper | output | W | Raw upper watermark |
| wm_lower | output | W | Raw lower watermark |
| avg_wm_upper | output | W | Average upper watermark |
| avg_wm_lower | output | W | Average lower watermark |
| arm_above | output | 1 | New above-breach interrupt enable |
| arm_below | output | 1 | New below-breach interrupt enable |

## Verification
The checker watches the handshake on every cycle. It also checks the properties every completion must have: the boost never exceeds the maximum after growth, the decayed boost is never left between zero and half a step, the arm bits follow the breach rules and the dependency rule, and the lower average watermark never lies above the average. The exact arithmetic can only be shown by the bench's directed scenarios. This covers the growth and decay values, the clamp and snap boundaries, the target formula with its truncation order, both raw watermarks, and a band larger than the average. The bench also shows that a `start` during a run leaves the completion time unchanged.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } bfu_state_e;

   // Order of the arithmetic passes. OP_TARGET must stay last, because it
   // consumes the results of OP_BOOST, OP_AVG_DIV and OP_COEF.
   typedef enum logic [2:0] {
      OP_BOOST   = 3'd0,
      OP_WM_HI   = 3'd1,
      OP_WM_LO   = 3'd2,
      OP_BAND    = 3'd3,
      OP_AVG_DIV = 3'd4,
      OP_COEF    = 3'd5,
      OP_TARGET  = 3'd6
   } bfu_op_e;

   localparam int unsigned PCT_DEN    = 100;
   localparam int unsigned PERMIL_DEN = 1000;
   localparam int unsigned SCALE_NUM  = 10000;

endpackage

// File: rtl/bfu_divider.sv
// Iterative restoring divider: PW-bit dividend, W-bit divisor,
// BITS quotient bits resolved per clock.
module bfu_divider #(
   parameter int W    = 32,
   parameter int PW   = 68,
   parameter int BITS = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW-1:0] num,
   input  logic [W-1:0]  den,
   output logic          done,
   output logic [PW-1:0] quot
);
   localparam int ITER  = PW / BITS;
   localparam int CNT_W = $clog2(ITER + 1);

   logic [W:0]       rem_q;
   logic [PW-1:0]    quo_q;
   logic [W-1:0]     den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   logic [W:0]       rem_nx;
   logic [PW-1:0]    quo_nx;
   logic [W:0]       shv;
   logic             ge;

   always_comb begin
      rem_nx = rem_q;
      quo_nx = quo_q;
      shv    = '0;
      ge     = 1'b0;
      for (int i = 0; i < BITS; i++) begin
         shv    = {rem_nx[W-1:0], quo_nx[PW-1]};
         ge     = rem_nx[W] | (shv >= {1'b0, den_q});
         rem_nx = ge ? (shv - {1'b0, den_q}) : shv;
         quo_nx = {quo_nx[PW-2:0], ge};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
            cnt_q <= CNT_W'(ITER);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end

   assign quot = quo_q;
endmodule

// File: rtl/bfu_arm_rules.sv
// Chooses the breach interrupt enables from the boost outcome.
module bfu_arm_rules #(
   parameter int W = 32
) (
   input  logic         brk_upper,
   input  logic         brk_lower,
   input  logic         capped,
   input  logic         zeroed,
   input  logic         arm_above_in,
   input  logic         arm_below_in,
   input  logic [W-1:0] avg,
   input  logic [W-1:0] dep_thr,
   input  logic [W-1:0] boost_new,
   output logic         arm_above,
   output logic         arm_below
);
   logic below_pre;

   always_comb begin
      if (brk_upper) begin
         arm_above = capped ? arm_above_in : 1'b1;
         below_pre = 1'b1;
      end else if (brk_lower) begin
         arm_above = 1'b1;
         below_pre = zeroed ? arm_below_in : 1'b1;
      end else begin
         arm_above = arm_above_in;
         below_pre = arm_below_in;
      end

      arm_below = below_pre;
      if (dep_thr != '0) begin
         if (avg >= dep_thr)
            arm_below = 1'b1;
         else if (boost_new == '0)
            arm_below = 1'b0;
      end
   end
endmodule

// File: rtl/boost_update_unit.sv
module boost_update_unit #(
   parameter int W           = 32,
   parameter int CW          = 16,
   parameter int PERIOD      = 12,
   parameter int STEP        = 16000,
   parameter int BAND_PERMIL = 6,
   parameter int DIV_BITS    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          brk_upper,
   input  logic          brk_lower,
   input  logic          arm_above_in,
   input  logic          arm_below_in,
   input  logic [W-1:0]  boost_in,
   input  logic [W-1:0]  avg_in,
   input  logic [W-1:0]  cur_khz,
   input  logic [W-1:0]  max_khz,
   input  logic [CW-1:0] up_pct,
   input  logic [CW-1:0] down_pct,
   input  logic [CW-1:0] up_thr,
   input  logic [CW-1:0] down_thr,
   input  logic [W-1:0]  dep_thr,
   output logic          busy,
   output logic          done,
   output logic [W-1:0]  boost_out,
   output logic [W-1:0]  target_out,
   output logic [W-1:0]  wm_upper,
   output logic [W-1:0]  wm_lower,
   output logic [W-1:0]  avg_wm_upper,
   output logic [W-1:0]  avg_wm_lower,
   output logic          arm_above,
   output logic          arm_below
);
   import bfu_pkg::*;

   localparam int PER_W = $clog2(PERIOD + 1);
   localparam int PW    = 2 * W + PER_W;
   localparam int SNAP  = STEP / 2;

   initial begin : param_check
      assert (W >= 16 && CW <= W) else $error("W must be >= 16 and >= CW");
      assert (PW % DIV_BITS == 0) else $error("DIV_BITS must divide PW");
      assert (PERIOD > 0 && STEP > 1) else $error("PERIOD and STEP must be positive");
   end

   bfu_state_e st_q;
   bfu_op_e    step_q;
   logic       busy_q, done_q, capped_q, zeroed_q, above_q, below_q;
   logic [W-1:0] boost_q, target_q, wmh_q, wml_q, avh_q, avl_q, avgp_q, coef_q;

   logic [PW-1:0] op_a, op_b, num, quot, grow, cur_scaled;
   logic [W-1:0]  op_d, band_w, avg_top;
   logic          div_go, div_done, above_n, below_n;

   // Operand selection for the single shared multiplier and the divider.
   assign cur_scaled = PW'(cur_khz) * PW'(PERIOD);

   always_comb begin
      op_a = '0;
      op_b = PW'(1);
      op_d = W'(PCT_DEN);
      case (step_q)
         OP_BOOST: begin
            op_a = PW'(boost_in);
            op_b = brk_upper ? PW'(up_pct) : PW'(down_pct);
         end
         OP_WM_HI:   begin op_a = cur_scaled; op_b = PW'(up_thr); end
         OP_WM_LO:   begin op_a = cur_scaled; op_b = PW'(down_thr); end
         OP_BAND: begin
            op_a = PW'(max_khz);
            op_b = PW'(BAND_PERMIL);
            op_d = W'(PERMIL_DEN);
         end
         OP_AVG_DIV: begin op_a = PW'(avg_in); op_d = W'(PERIOD); end
         OP_COEF:    begin op_a = PW'(SCALE_NUM); op_d = W'(up_thr); end
         OP_TARGET:  begin op_a = PW'(avgp_q); op_b = PW'(coef_q); end
         default:    op_a = '0;
      endcase
   end

   assign num    = op_a * op_b;
   assign div_go = (st_q == ST_ISSUE);

   bfu_divider #(.W(W), .PW(PW), .BITS(DIV_BITS)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_go),
      .num   (num),
      .den   (op_d),
      .done  (div_done),
      .quot  (quot)
   );

   assign grow    = quot + PW'(STEP);
   assign band_w  = quot[W-1:0] * W'(PERIOD);
   assign avg_top = (avg_in > band_w) ? avg_in : band_w;

   bfu_arm_rules #(.W(W)) u_arm (
      .brk_upper    (brk_upper),
      .brk_lower    (brk_lower),
      .capped       (capped_q),
      .zeroed       (zeroed_q),
      .arm_above_in (arm_above_in),
      .arm_below_in (arm_below_in),
      .avg          (avg_in),
      .dep_thr      (dep_thr),
      .boost_new    (boost_q),
      .arm_above    (above_n),
      .arm_below    (below_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  step_q <= OP_BOOST;
         busy_q <= 1'b0;   done_q <= 1'b0;
         capped_q <= 1'b0; zeroed_q <= 1'b0;
         above_q <= 1'b0;  below_q <= 1'b0;
         boost_q <= '0;    target_q <= '0;
         wmh_q <= '0;      wml_q <= '0;
         avh_q <= '0;      avl_q <= '0;
         avgp_q <= '0;     coef_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_ISSUE;
               step_q <= OP_BOOST;
               busy_q <= 1'b1;
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: if (div_done) begin
               case (step_q)
                  OP_BOOST: begin
                     capped_q <= 1'b0;
                     zeroed_q <= 1'b0;
                     if (brk_upper) begin
                        if (grow >= PW'(max_khz)) begin
                           boost_q  <= max_khz;
                           capped_q <= 1'b1;
                        end else begin
                           boost_q <= grow[W-1:0];
                        end
                     end else if (brk_lower) begin
                        if (quot < PW'(SNAP)) begin
                           boost_q  <= '0;
                           zeroed_q <= 1'b1;
                        end else begin
                           boost_q <= quot[W-1:0];
                        end
                     end else begin
                        boost_q <= boost_in;
                     end
                  end
                  OP_WM_HI:   wmh_q <= quot[W-1:0];
                  OP_WM_LO:   wml_q <= quot[W-1:0];
                  OP_BAND: begin
                     avh_q <= avg_in + band_w;
                     avl_q <= avg_top - band_w;
                  end
                  OP_AVG_DIV: avgp_q <= quot[W-1:0];
                  OP_COEF:    coef_q <= quot[W-1:0];
                  OP_TARGET: begin
                     target_q <= quot[W-1:0] + boost_q;
                     above_q  <= above_n;
                     below_q  <= below_n;
                  end
                  default: ;
               endcase
               if (step_q == OP_TARGET) begin
                  st_q   <= ST_IDLE;
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  step_q <= bfu_op_e'(step_q + 3'd1);
                  st_q   <= ST_ISSUE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy         = busy_q;
   assign done         = done_q;
   assign boost_out    = boost_q;
   assign target_out   = target_q;
   assign wm_upper     = wmh_q;
   assign wm_lower     = wml_q;
   assign avg_wm_upper = avh_q;
   assign avg_wm_lower = avl_q;
   assign arm_above    = above_q;
   assign arm_below    = below_q;
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
   parameter int W    = 32,
   parameter int SNAP = 8000
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic         brk_upper,
   input logic         brk_lower,
   input logic [W-1:0] boost_in,
   input logic [W-1:0] avg_in,
   input logic [W-1:0] max_khz,
   input logic [W-1:0] dep_thr,
   input logic [W-1:0] boost_out,
   input logic [W-1:0] avg_wm_lower,
   input logic         arm_above,
   input logic         arm_below
);
   AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R1
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R1
   AST_UP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && brk_upper) |-> (boost_out <= max_khz)); // R2
   AST_UP_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      (done && brk_upper && boost_out != '0) |-> arm_below); // R2
   AST_LO_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !brk_upper && brk_lower) |-> (boost_out == '0 || boost_out >= W'(SNAP))); // R3
   AST_LO_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !brk_upper && brk_lower) |-> arm_above); // R3
   AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !brk_upper && !brk_lower) |-> (boost_out == boost_in)); // R4
   AST_DEP_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dep_thr != '0 && avg_in >= dep_thr) |-> arm_below); // R5
   AST_DEP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dep_thr != '0 && avg_in < dep_thr && boost_out == '0) |-> !arm_below); // R5
   AST_AVG_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (avg_wm_lower <= avg_in)); // R8
endmodule

bind boost_update_unit bfu_checker #(.W(W), .SNAP(STEP / 2)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .busy         (busy),
   .done         (done),
   .brk_upper    (brk_upper),
   .brk_lower    (brk_lower),
   .boost_in     (boost_in),
   .avg_in       (avg_in),
   .max_khz      (max_khz),
   .dep_thr      (dep_thr),
   .boost_out    (boost_out),
   .avg_wm_lower (avg_wm_lower),
   .arm_above    (arm_above),
   .arm_below    (arm_below)
);

// File: tb/boost_update_unit_test.sv
`timescale 1ns/1ps
module boost_update_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        i_up = 1'b0, i_lo = 1'b0, i_ain = 1'b0, i_bin = 1'b0;
   logic [31:0] i_boost = '0, i_avg = '0, i_cur = '0, i_max = '0, i_dep = '0;
   logic [15:0] i_upp = '0, i_dnp = '0, i_uth = 16'd1, i_dth = '0;
   logic        busy, done, arm_above, arm_below;
   logic [31:0] boost_out, target_out, wm_upper, wm_lower, avg_wm_upper, avg_wm_lower;

   int total = 0;
   int bad = 0;
   int lat_ref = 0;

   always #5 clk = ~clk;

   boost_update_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .brk_upper(i_up), .brk_lower(i_lo),
      .arm_above_in(i_ain), .arm_below_in(i_bin),
      .boost_in(i_boost), .avg_in(i_avg), .cur_khz(i_cur), .max_khz(i_max),
      .up_pct(i_upp), .down_pct(i_dnp), .up_thr(i_uth), .down_thr(i_dth),
      .dep_thr(i_dep),
      .busy(busy), .done(done), .boost_out(boost_out), .target_out(target_out),
      .wm_upper(wm_upper), .wm_lower(wm_lower),
      .avg_wm_upper(avg_wm_upper), .avg_wm_lower(avg_wm_lower),
      .arm_above(arm_above), .arm_below(arm_below)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      summary();
      $finish;
   end

   // Expected results worked out from the requirements (STEP 16000, PERIOD 12, band 6 per mille).
   task automatic model(output logic [31:0] eb, et, ewh, ewl, eah, eal, output logic ea, ebl);
      logic [127:0] t;
      logic [31:0] band, top;
      ea  = i_ain;
      ebl = i_bin;
      eb  = i_boost;
      if (i_up) begin
         t = 128'(i_boost) * i_upp / 100 + 16000;
         ebl = 1'b1;
         if (t >= 128'(i_max)) eb = i_max;
         else begin eb = t[31:0]; ea = 1'b1; end
      end else if (i_lo) begin
         t = 128'(i_boost) * i_dnp / 100;
         ea = 1'b1;
         if (t < 128'd8000) eb = 32'd0;
         else begin eb = t[31:0]; ebl = 1'b1; end
      end
      if (i_dep != 0) begin
         if (i_avg >= i_dep) ebl = 1'b1;
         else if (eb == 0) ebl = 1'b0;
      end
      t   = ((128'(i_avg) / 12) * (128'd10000 / i_uth)) / 100;
      et  = t[31:0] + eb;
      t   = 128'(i_cur) * 12 * i_uth / 100;
      ewh = t[31:0];
      t   = 128'(i_cur) * 12 * i_dth / 100;
      ewl = t[31:0];
      t    = 128'(i_max) * 6 / 1000;
      band = t[31:0] * 32'd12;
      eah  = i_avg + band;
      top  = (i_avg > band) ? i_avg : band;
      eal  = top - band;
   endtask

   // Starts one update, optionally pulses start again mid-run, checks every output.
   task automatic run(input string tag, input bit extra_start);
      logic [31:0] eb, et, ewh, ewl, eah, eal;
      logic ea, ebl;
      int cyc;
      model(eb, et, ewh, ewl, eah, eal, ea, ebl);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      chk({tag, " R1 busy after start"}, 32'(busy), 32'd1);
      while (!done && cyc < 3000) begin
         @(negedge clk);
         start = (extra_start && cyc == 20);
         cyc++;
      end
      start = 1'b0;
      chk({tag, " R1 done seen"}, 32'(done), 32'd1);
      chk({tag, " R1 busy low at done"}, 32'(busy), 32'd0);
      if (lat_ref == 0) lat_ref = cyc;
      else chk({tag, " R1 latency"}, 32'(cyc), 32'(lat_ref));
      chk({tag, " boost"}, boost_out, eb);
      chk({tag, " arm_above"}, 32'(arm_above), 32'(ea));
      chk({tag, " arm_below"}, 32'(arm_below), 32'(ebl));
      chk({tag, " R6 target"}, target_out, et);
      chk({tag, " R7 wm_upper"}, wm_upper, ewh);
      chk({tag, " R7 wm_lower"}, wm_lower, ewl);
      chk({tag, " R8 avg_wm_upper"}, avg_wm_upper, eah);
      chk({tag, " R8 avg_wm_lower"}, avg_wm_lower, eal);
      @(negedge clk);
      chk({tag, " R1 done one cycle"}, 32'(done), 32'd0);
      chk({tag, " R1 outputs held"}, boost_out, eb);
   endtask

   task automatic set_a();
      i_upp = 16'd200; i_dnp = 16'd50; i_uth = 16'd60; i_dth = 16'd40; i_dep = 32'd0;
      i_cur = 32'd400000; i_max = 32'd924000;
   endtask

   task automatic set_b();
      i_upp = 16'd800; i_dnp = 16'd90; i_uth = 16'd27; i_dth = 16'd10; i_dep = 32'd50000;
      i_cur = 32'd204000; i_max = 32'd924000;
   endtask

   task automatic t_reset();
      chk("R9 busy at reset", 32'(busy), 32'd0);
      chk("R9 done at reset", 32'(done), 32'd0);
      chk("R9 boost at reset", boost_out, 32'd0);
      chk("R9 target at reset", target_out, 32'd0);
      chk("R9 avg_wm_upper at reset", avg_wm_upper, 32'd0);
      chk("R9 arm bits at reset", 32'({arm_above, arm_below}), 32'd0);
   endtask

   task automatic t_upper_grow();
      set_a();
      i_up = 1; i_lo = 0; i_ain = 0; i_bin = 0; i_boost = 32'd10000; i_avg = 32'd3000000;
      run("R2 growth", 1'b0);
   endtask

   task automatic t_upper_clamp();
      set_a();
      i_up = 1; i_lo = 0; i_ain = 0; i_bin = 0; i_boost = 32'd500000; i_avg = 32'd2500000;
      run("R2 clamp", 1'b0);
      chk("R2 clamp equals max", boost_out, i_max);
   endtask

   task automatic t_lower_decay();
      set_b();
      i_up = 0; i_lo = 1; i_ain = 0; i_bin = 0; i_boost = 32'd100000; i_avg = 32'd40000;
      run("R3 decay", 1'b0);
      chk("R3 decay value", boost_out, 32'd90000);
   endtask

   task automatic t_lower_snap();
      set_a();
      i_up = 0; i_lo = 1; i_ain = 0; i_bin = 1; i_boost = 32'd15000; i_avg = 32'd900000;
      run("R3 snap", 1'b0);
      chk("R3 snapped to zero", boost_out, 32'd0);
      i_boost = 32'd16000; i_bin = 0;
      run("R3 at half step", 1'b0);
      chk("R3 half step kept", boost_out, 32'd8000);
   endtask

   task automatic t_priority();
      set_a();
      i_up = 1; i_lo = 1; i_ain = 0; i_bin = 0; i_boost = 32'd20000; i_avg = 32'd1200000;
      run("R4 both flags", 1'b0);
      chk("R4 upper wins", boost_out, 32'd56000);
   endtask

   task automatic t_none();
      set_b();
      i_up = 0; i_lo = 0; i_ain = 1; i_bin = 0; i_boost = 32'd77000; i_avg = 32'd50000;
      run("R4 no flag", 1'b0);
      chk("R4 boost passthrough", boost_out, 32'd77000);
   endtask

   task automatic t_dependency();
      set_b();
      i_up = 0; i_lo = 1; i_ain = 0; i_bin = 1; i_boost = 32'd5000; i_avg = 32'd30000;
      run("R5 below dep boost zero", 1'b0);
      chk("R5 below cleared", 32'(arm_below), 32'd0);
      i_avg = 32'd50000; i_bin = 0;
      run("R5 avg at dep", 1'b0);
      chk("R5 below forced", 32'(arm_below), 32'd1);
   endtask

   task automatic t_avg_floor();
      set_a();
      i_up = 0; i_lo = 0; i_ain = 0; i_bin = 0; i_boost = 32'd0; i_avg = 32'd1000;
      run("R8 band above avg", 1'b0);
      chk("R8 lower floor zero", avg_wm_lower, 32'd0);
   endtask

   task automatic t_busy_start();
      set_a();
      i_up = 1; i_lo = 0; i_ain = 1; i_bin = 1; i_boost = 32'd30000; i_avg = 32'd2000000;
      run("R1 start during busy", 1'b1);
      repeat (40) @(negedge clk);
      chk("R1 no second run", 32'({busy, done}), 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_upper_grow();
      t_upper_clamp();
      t_lower_decay();
      t_lower_snap();
      t_priority();
      t_none();
      t_dependency();
      t_avg_floor();
      t_busy_start();
      summary();
      $finish;
   end
endmodule